// File: doc/BRIEF.md
# Instruction-Boundary Interrupt Sampler

This block collects interrupt requests from two active-low external pins and from a set of internal peripheral request lines. It keeps one pending flag per source and decides at each instruction boundary whether the CPU must divert to an interrupt. The CPU sequencer supplies two markers. `last_cycle` is high in the final cycle of the running instruction. `single_cycle` is high in the only cycle of a one-cycle instruction. Either marker makes that cycle a poll point.

A flag counts at a poll point only if it was already active in the cycle before that poll point. In a multi-cycle instruction that cycle is the next-to-last one. In a one-cycle instruction it is the last cycle of the previous instruction. A flag that rises later waits for the next boundary. When a poll point finds an eligible, enabled source, the block raises `svc_req` for one cycle in the cycle after the poll and presents the winning source number on `svc_vec`.

The controller has two states. In `CTL_EXEC` an instruction runs and no strobe is driven. In `CTL_VECTOR` the service strobe is driven. A take moves the controller to `CTL_VECTOR` from either state, so back-to-back takes are possible. With no take it returns to, or stays in, `CTL_EXEC`. Each external pin also tracks its synchronized level in a two-state detector. A move from `PIN_HIGH` to `PIN_LOW` is a falling edge. Any other transition only follows the pin.

Top module: `irq_boundary_sampler`

## Requirements
- R1: While reset is low, and in the first cycle after it, `svc_req` is 0 and `svc_vec` is 0, and no flag is pending.
- R2: A flag that first becomes active in the poll cycle itself is not taken at that poll. It is taken at the next poll point.
- R3: A flag active in the next-to-last cycle of a multi-cycle instruction is taken when `last_cycle` is high. `svc_req` is then 1 in the following cycle.
- R4: A cycle with `single_cycle` high is a poll point even when `last_cycle` is low. A flag active in the previous cycle is eligible there.
- R5: Source numbers are fixed: external pin 0 is 0, external pin 1 is 1, and peripheral line k is 2+k. Among eligible enabled sources the lowest number wins and appears on `svc_vec`.
- R6: A source is taken only if its `src_en` bit (bit n for source n) and `global_en` are both 1 at the poll. A masked peripheral request stays pending and is taken at a later poll once enabled.
- R7: `svc_req` lasts one cycle per take. `svc_vec` is 0 whenever `svc_req` is 0.
- R8: External pins are sampled every cycle through two flops. A low pulse one cycle wide is caught in falling-edge mode (`ext_edge_mode` bit = 1). A pin that falls before clock edge k has its flag active from edge k+2, so it is first taken at the poll that ends the following cycle.
- R9: An edge-mode flag clears when its own vector is taken, so one falling edge yields exactly one service.
- R10: In level mode (`ext_edge_mode` bit = 0) the flag follows the inverted synchronized pin. It is not cleared by a take, and once the pin returns high no service follows.
- R11: Each peripheral flag follows its request line with one register of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_irq_n | input | 2 | Active-low external interrupt pins, asynchronous |
| ext_edge_mode | input | 2 | Per pin: 1 = falling edge, 0 = low level |
| periph_req | input | NUM_PERIPH | Peripheral request lines, active high |
| src_en | input | NUM_PERIPH+2 | Per-source enable, bit n for source n |
| global_en | input | 1 | Master enable for all sources |
| last_cycle | input | 1 | Final cycle of the current instruction |
| single_cycle | input | 1 | Only cycle of a one-cycle instruction |
| svc_req | output | 1 | One-cycle service strobe |
| svc_vec | output | clog2(NUM_PERIPH+2) | Winning source number, valid with `svc_req` |

## Verification
A stale eligibility snapshot shows up as a strobe one poll too early or one poll too late. The bench therefore checks the exact cycle after each poll in which a flag rises. A controller stuck in `CTL_VECTOR` shows as a strobe in a cycle that has no poll point, which is visible one cycle later. A pin detector that stays in `PIN_HIGH` or fails to clear its flag shows as a second service in the very next single-cycle poll.

// File: rtl/irq_sampler_pkg.sv
package irq_sampler_pkg;

    // number of external interrupt pins feeding the low source numbers
    localparam int EXT_COUNT = 2;

    typedef enum logic {
        PIN_HIGH = 1'b0,
        PIN_LOW  = 1'b1
    } pin_state_t;

    typedef enum logic {
        CTL_EXEC   = 1'b0,
        CTL_VECTOR = 1'b1
    } ctl_state_t;

endpackage

// File: rtl/irq_pin_front.sv
module irq_pin_front
    import irq_sampler_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic clr,
    output logic flag
);

    logic       sync_a_q;
    logic       sync_b_q;
    pin_state_t pst_q;
    pin_state_t pst_d;
    logic       fall;
    logic       flag_q;

    // two-flop synchronizer, idles high (pin released)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_a_q <= 1'b1;
            sync_b_q <= 1'b1;
        end else begin
            sync_a_q <= pin_n;
            sync_b_q <= sync_a_q;
        end
    end

    // level tracker: PIN_HIGH -> PIN_LOW marks a falling edge
    always_comb begin
        pst_d = pst_q;
        unique case (pst_q)
            PIN_HIGH: if (!sync_b_q) pst_d = PIN_LOW;
            PIN_LOW:  if (sync_b_q)  pst_d = PIN_HIGH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pst_q <= PIN_HIGH;
        else        pst_q <= pst_d;
    end

    assign fall = (pst_q == PIN_HIGH) && (pst_d == PIN_LOW);

    // flag: sticky in edge mode until taken, transparent in level mode
    always_ff @(posedge clk) begin
        if (!rst_n)         flag_q <= 1'b0;
        else if (edge_mode) flag_q <= fall | (flag_q & ~clr);
        else                flag_q <= ~sync_b_q;
    end

    assign flag = flag_q;

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int NUM_SRC = 6,
    parameter int VEC_W   = 3
) (
    input  logic [NUM_SRC-1:0] req,
    output logic               any,
    output logic [VEC_W-1:0]   idx,
    output logic [NUM_SRC-1:0] hit
);

    logic [NUM_SRC:0] seen;

    assign seen[0] = 1'b0;

    // ripple chain: a source hits only if no lower-numbered one requests
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_chain
        assign hit[g]    = req[g] & ~seen[g];
        assign seen[g+1] = seen[g] | req[g];
    end

    assign any = seen[NUM_SRC];

    always_comb begin
        idx = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (hit[i]) idx = VEC_W'(i);
        end
    end

endmodule

// File: rtl/irq_poll_ctrl.sv
module irq_poll_ctrl
    import irq_sampler_pkg::*;
#(
    parameter int NUM_SRC = 6,
    parameter int VEC_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               poll,
    input  logic               any,
    input  logic [VEC_W-1:0]   idx,
    input  logic [NUM_SRC-1:0] hit,
    output logic [NUM_SRC-1:0] clr,
    output logic               svc_req,
    output logic [VEC_W-1:0]   svc_vec
);

    ctl_state_t       state_q;
    ctl_state_t       state_d;
    logic             take;
    logic [VEC_W-1:0] vec_q;

    assign take = poll & any;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CTL_EXEC:   state_d = take ? CTL_VECTOR : CTL_EXEC;
            CTL_VECTOR: state_d = take ? CTL_VECTOR : CTL_EXEC;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CTL_EXEC;
        else        state_q <= state_d;
    end

    // output process: vector registered alongside the strobe state
    always_ff @(posedge clk) begin
        if (!rst_n)    vec_q <= '0;
        else if (take) vec_q <= idx;
        else           vec_q <= '0;
    end

    assign svc_req = (state_q == CTL_VECTOR);
    assign svc_vec = vec_q;
    assign clr     = take ? hit : '0;

endmodule

// File: rtl/irq_boundary_sampler.sv
module irq_boundary_sampler
    import irq_sampler_pkg::*;
#(
    parameter  int NUM_PERIPH = 4,
    localparam int NUM_SRC    = EXT_COUNT + NUM_PERIPH,
    localparam int VEC_W      = $clog2(NUM_SRC)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [EXT_COUNT-1:0]  ext_irq_n,
    input  logic [EXT_COUNT-1:0]  ext_edge_mode,
    input  logic [NUM_PERIPH-1:0] periph_req,
    input  logic [NUM_SRC-1:0]    src_en,
    input  logic                  global_en,
    input  logic                  last_cycle,
    input  logic                  single_cycle,
    output logic                  svc_req,
    output logic [VEC_W-1:0]      svc_vec
);

    logic [NUM_SRC-1:0]    flag;
    logic [NUM_SRC-1:0]    snap_q;
    logic [NUM_SRC-1:0]    cand;
    logic [NUM_SRC-1:0]    hit;
    logic [NUM_SRC-1:0]    clr;
    logic [NUM_PERIPH-1:0] pflag_q;
    logic                  any;
    logic [VEC_W-1:0]      idx;
    logic                  poll;

    for (genvar e = 0; e < EXT_COUNT; e++) begin : g_ext
        irq_pin_front u_front (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_n     (ext_irq_n[e]),
            .edge_mode (ext_edge_mode[e]),
            .clr       (clr[e]),
            .flag      (flag[e])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pflag_q <= '0;
        else        pflag_q <= periph_req;
    end

    assign flag[NUM_SRC-1:EXT_COUNT] = pflag_q;

    // flags as they stood in the cycle before the poll point
    always_ff @(posedge clk) begin
        if (!rst_n) snap_q <= '0;
        else        snap_q <= flag;
    end

    assign poll = last_cycle | single_cycle;
    assign cand = snap_q & flag & src_en & {NUM_SRC{global_en}};

    irq_prio_pick #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_pick (
        .req (cand),
        .any (any),
        .idx (idx),
        .hit (hit)
    );

    irq_poll_ctrl #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .poll    (poll),
        .any     (any),
        .idx     (idx),
        .hit     (hit),
        .clr     (clr),
        .svc_req (svc_req),
        .svc_vec (svc_vec)
    );

endmodule

// File: rtl/irq_boundary_sampler_chk.sv
module irq_boundary_sampler_chk #(
    parameter int NUM_SRC = 6,
    parameter int VEC_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_en,
    input logic               global_en,
    input logic               last_cycle,
    input logic               single_cycle,
    input logic               svc_req,
    input logic [VEC_W-1:0]   svc_vec
);

    logic [NUM_SRC-1:0] en_d;

    always_ff @(posedge clk) en_d <= src_en;

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !svc_req);

    assert_strobe_after_poll_R4: assert property (@(posedge clk) disable iff (!rst_n)
        svc_req |-> $past(last_cycle || single_cycle));

    assert_global_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        svc_req |-> $past(global_en));

    assert_source_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        svc_req |-> en_d[svc_vec]);

    assert_vec_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !svc_req |-> (svc_vec == '0));

    assert_no_stray_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(last_cycle || single_cycle) |=> !svc_req);

endmodule

bind irq_boundary_sampler irq_boundary_sampler_chk #(
    .NUM_SRC (NUM_SRC),
    .VEC_W   (VEC_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .src_en       (src_en),
    .global_en    (global_en),
    .last_cycle   (last_cycle),
    .single_cycle (single_cycle),
    .svc_req      (svc_req),
    .svc_vec      (svc_vec)
);

// File: tb/test_irq_boundary_sampler.sv
`timescale 1ns/1ps
module test_irq_boundary_sampler;

    localparam int NP = 4;
    localparam int NS = NP + 2;
    localparam int VW = $clog2(NS);
    localparam int NROWS = 10;

    // row: {periph_req[3:0], src_en[5:0], global_en, use_single, exp_req, exp_vec[2:0]}
    localparam logic [15:0] ROWS [NROWS] = '{
        {4'b0001, 6'b111111, 1'b1, 1'b0, 1'b1, 3'd2},
        {4'b1010, 6'b111111, 1'b1, 1'b0, 1'b1, 3'd3},
        {4'b1100, 6'b111111, 1'b1, 1'b0, 1'b1, 3'd4},
        {4'b1000, 6'b111111, 1'b1, 1'b0, 1'b1, 3'd5},
        {4'b1111, 6'b111011, 1'b1, 1'b0, 1'b1, 3'd3},
        {4'b0101, 6'b111111, 1'b0, 1'b0, 1'b0, 3'd0},
        {4'b0000, 6'b111111, 1'b1, 1'b0, 1'b0, 3'd0},
        {4'b1000, 6'b011111, 1'b1, 1'b0, 1'b0, 3'd0},
        {4'b0110, 6'b110111, 1'b1, 1'b0, 1'b1, 3'd4},
        {4'b0010, 6'b111111, 1'b1, 1'b1, 1'b1, 3'd3}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    ext_irq_n = 2'b11;
    logic [1:0]    ext_edge_mode = 2'b01;
    logic [NP-1:0] periph_req = '0;
    logic [NS-1:0] src_en = '1;
    logic          global_en = 1'b1;
    logic          last_cycle = 1'b0;
    logic          single_cycle = 1'b0;
    logic          svc_req;
    logic [VW-1:0] svc_vec;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irq_boundary_sampler #(.NUM_PERIPH(NP)) i_irq_boundary_sampler (
        .clk           (clk),
        .rst_n         (rst_n),
        .ext_irq_n     (ext_irq_n),
        .ext_edge_mode (ext_edge_mode),
        .periph_req    (periph_req),
        .src_en        (src_en),
        .global_en     (global_en),
        .last_cycle    (last_cycle),
        .single_cycle  (single_cycle),
        .svc_req       (svc_req),
        .svc_vec       (svc_vec)
    );

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_out(string tag, int ereq, int evec);
        check({tag, " req"}, int'(svc_req), ereq);
        check({tag, " vec"}, int'(svc_vec), evec);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        tick(3);
        check_out("R1 in reset", 0, 0);
        rst_n = 1'b1;
        tick();
        check_out("R1 after reset", 0, 0);
        tick(4);

        // R3 / R5 / R6 / R4 / R11 table walk
        for (int r = 0; r < NROWS; r++) begin
            logic [15:0] row;
            row = ROWS[r];
            periph_req = row[15:12];
            src_en     = row[11:6];
            global_en  = row[5];
            tick(2);
            if (row[4]) single_cycle = 1'b1;
            else        last_cycle   = 1'b1;
            tick();
            check_out($sformatf("R3 R5 R6 R11 row %0d", r), int'(row[3]), int'(row[2:0]));
            last_cycle = 1'b0;
            single_cycle = 1'b0;
            periph_req = '0;
            tick();
            check_out($sformatf("R7 row %0d", r), 0, 0);
            tick(2);
        end
        src_en = '1;
        global_en = 1'b1;

        // R2 late flag, then R4 single-cycle poll takes it
        periph_req = 4'b0001;
        tick();
        last_cycle = 1'b1;
        tick();
        check_out("R2 late flag", 0, 0);
        single_cycle = 1'b1;
        tick();
        check_out("R4 single cycle", 1, 2);
        last_cycle = 1'b0;
        single_cycle = 1'b0;
        periph_req = '0;
        tick();
        check_out("R7 one strobe", 0, 0);
        tick(3);

        // R6 masked request stays pending
        src_en = 6'b110111;
        periph_req = 4'b0010;
        tick(2);
        last_cycle = 1'b1;
        tick();
        check_out("R6 masked", 0, 0);
        last_cycle = 1'b0;
        src_en = '1;
        tick(2);
        last_cycle = 1'b1;
        tick();
        check_out("R6 enabled later", 1, 3);
        last_cycle = 1'b0;
        periph_req = '0;
        tick(4);

        // R8 one-cycle pulse in edge mode, R9 single service
        ext_irq_n[0] = 1'b0;
        tick();
        ext_irq_n[0] = 1'b1;
        tick(2);
        last_cycle = 1'b1;
        tick();
        check_out("R8 not yet eligible", 0, 0);
        tick();
        check_out("R8 pulse taken", 1, 0);
        tick();
        check_out("R9 edge flag cleared", 0, 0);
        last_cycle = 1'b0;
        tick(4);

        // R10 level mode: stays pending across takes
        ext_irq_n[1] = 1'b0;
        tick(4);
        last_cycle = 1'b1;
        tick();
        check_out("R10 level taken", 1, 1);
        tick();
        check_out("R10 level again", 1, 1);
        last_cycle = 1'b0;
        ext_irq_n[1] = 1'b1;
        tick(6);
        last_cycle = 1'b1;
        tick();
        check_out("R10 released", 0, 0);
        last_cycle = 1'b0;
        tick(2);

        // R5 external beats peripheral
        ext_irq_n[1] = 1'b0;
        periph_req = 4'b0001;
        tick(4);
        last_cycle = 1'b1;
        tick();
        check_out("R5 ext over periph", 1, 1);
        last_cycle = 1'b0;
        ext_irq_n[1] = 1'b1;
        periph_req = '0;
        tick(6);

        // R1 reset in mid-flight clears pending
        periph_req = 4'b0100;
        tick(2);
        rst_n = 1'b0;
        periph_req = '0;
        tick(2);
        rst_n = 1'b1;
        last_cycle = 1'b1;
        tick();
        check_out("R1 flags cleared", 0, 0);
        last_cycle = 1'b0;
        tick(2);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule